// File: doc/BRIEF.md
# CAN Transceiver Mode Controller with Wake Filter

This block is the digital control core of a high-speed CAN transceiver. It takes the system operating mode, a two-bit CAN mode request, the supply and battery status, the transmit-data input and the sampled bus level. From these it picks one of five transceiver states: off, offline, offline-bias, listen-only and active. It drives the transmitter enable, the choice of bus bias level (ground or mid-level), a transmitter-ready status, a sticky wake flag and an override that pulls the receive line low when a wake is seen.

While the transceiver sits in one of the two offline states, the bias moves by itself. It goes to ground after a quiet bus period and back to mid-level as soon as the bus moves. With wake enabled, a timed filter watches for a dominant, recessive, dominant pattern on the bus. Every phase length and both timeouts are parameters counted in clock cycles. The analog driver, receiver and bias network are outside this block.

Top module: `can_xcvr_ctrl`

## Requirements
- R1: System mode codes are 0 off, 1 reset, 2 standby, 3 normal, 4 forced normal, 5 overtemperature; codes 6 and 7 act as off. State codes on `xcvr_mode` are 0 off, 1 offline, 2 offline-bias, 3 listen-only, 4 active. In normal system mode, `can_mode` 01 or 10 selects active, 11 selects listen-only and 00 selects the offline family. In standby and reset the transceiver is held in the offline family (offline or offline-bias), one cycle after the input.
- R2: While not already active, a low `txd` turns an active request into listen-only. Active is entered on the cycle after `txd` goes high. A low `txd` in active mode does not leave it.
- R3: In normal system mode with `can_mode` 01, a low `sup_ok` moves the transceiver out of active into offline-bias on the next cycle.
- R4: In normal system mode with `can_mode` 10, active is kept while `sup_ok` is low. A move to reset system mode then places it in the offline family.
- R5: In forced normal system mode the transceiver is active when `sup_ok` is high and listen-only when it is low.
- R6: In offline-bias, `SIL_TO` cycles without a bus level change lead to offline. In offline, a bus level change or a wake detection leads back to offline-bias.
- R7: With `wake_en` high and the state offline or offline-bias, three phases set `wake_evt` and `rxd_low`: a dominant phase of at least `DOM_MIN` cycles, then a recessive phase of at least `REC_MIN` cycles, then a dominant phase of at least `DOM_MIN` cycles. With `wake_en` low the same pattern sets nothing.
- R8: A high `bat_uv`, or system mode off or overtemperature, gives the off state with `tx_en` and `bias_mid` low. Once these clear, the next state is offline.
- R9: A partly matched pattern that is not finished within `WAKE_TO` cycles of its first qualified dominant phase is dropped and gives no wake. A long enough dominant phase after that can start a new attempt.
- R10: Pulses shorter than the minimum inside a phase gap are tolerated. A recessive phase shorter than `REC_MIN` does not count as the middle phase.
- R11: `wake_evt` stays set until a high `wake_clr` sample. That sample clears it and releases `rxd_low`. A new detection on the same cycle wins over the clear.
- R12: `bias_mid` is high in offline-bias, listen-only and active. `tx_en` is high only in active. `tx_rdy` is high when the state is active and `sup_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_mode | input | 3 | System operating mode code |
| can_mode | input | 2 | Requested CAN mode |
| wake_en | input | 1 | Enables remote wake detection |
| sup_ok | input | 1 | Supply is above 90 % of nominal |
| bat_uv | input | 1 | Battery below the CAN undervoltage level |
| txd | input | 1 | Transmit data input (low = dominant request) |
| bus_dom | input | 1 | Sampled bus level, 1 = dominant |
| wake_clr | input | 1 | Write-one-to-clear strobe for the wake flag |
| tx_en | output | 1 | Transmitter enable |
| bias_mid | output | 1 | 1 = bias at mid-level, 0 = ground or floating |
| tx_rdy | output | 1 | Transmitter ready status |
| wake_evt | output | 1 | Sticky wake event flag |
| rxd_low | output | 1 | Forces the receive line low |
| xcvr_mode | output | 3 | Current transceiver state code |

## Verification
The bench stresses the wake filter with four bus patterns:
- A clean pattern.
- A pattern whose middle recessive phase is too short. A filter that counted it would raise a false wake.
- A pattern cut by a one-cycle dominant glitch. A filter that restarted on the glitch would miss a genuine wake.
- A pattern that overruns the timeout. A filter with no window would wake on slow bus traffic.

It also checks the start of active mode while `txd` is held low; a design without this guard would jam the bus. It checks the supply dip under mode codes 01 and 10; mixing them up either drops the bus in mode 10 or keeps a weak driver on in mode 01. Finally it checks that the offline states move by themselves on silence and on bus activity.

// File: rtl/can_xcvr_ctrl.sv
module can_xcvr_ctrl #(
  parameter int DOM_MIN = 250,
  parameter int REC_MIN = 250,
  parameter int WAKE_TO = 50000,
  parameter int SIL_TO  = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sys_mode,
  input  logic [1:0] can_mode,
  input  logic       wake_en,
  input  logic       sup_ok,
  input  logic       bat_uv,
  input  logic       txd,
  input  logic       bus_dom,
  input  logic       wake_clr,
  output logic       tx_en,
  output logic       bias_mid,
  output logic       tx_rdy,
  output logic       wake_evt,
  output logic       rxd_low,
  output logic [2:0] xcvr_mode
);
  localparam int RMAX = (DOM_MIN > REC_MIN) ? DOM_MIN : REC_MIN;
  localparam int RW = $clog2(RMAX + 1);
  localparam int WW = $clog2(WAKE_TO + 1);
  localparam int SW = $clog2(SIL_TO + 1);
  localparam logic [RW-1:0] DOM_L  = RW'(DOM_MIN);
  localparam logic [RW-1:0] REC_L  = RW'(REC_MIN);
  localparam logic [RW-1:0] RMAX_L = RW'(RMAX);
  localparam logic [WW-1:0] WIN_L  = WW'(WAKE_TO - 1);
  localparam logic [SW-1:0] SIL_L  = SW'(SIL_TO);

  localparam logic [2:0] S_OFF = 3'd0, S_RST = 3'd1, S_STBY = 3'd2,
                         S_NORM = 3'd3, S_FNM = 3'd4, S_OVT = 3'd5;
  localparam logic [2:0] M_OFF = 3'd0, M_OFFL = 3'd1, M_OFFB = 3'd2,
                         M_LSTN = 3'd3, M_ACT = 3'd4;

  logic [2:0]    mode, nxt, want;
  logic          bus_q;
  logic [RW-1:0] run;
  logic [WW-1:0] win;
  logic [SW-1:0] sil;
  logic [1:0]    stage;

  wire bus_chg  = bus_dom ^ bus_q;
  wire silent   = (sil == SIL_L);
  wire wk_on    = wake_en && (mode == M_OFFL || mode == M_OFFB);
  wire dom_ok   = bus_q && (run >= DOM_L);
  wire rec_ok   = !bus_q && (run >= REC_L);
  wire wake_hit = wk_on && (stage == 2'd2) && dom_ok;
  wire kill     = bat_uv || sys_mode == S_OFF || sys_mode >= S_OVT;

  always_comb begin
    want = M_OFFB;
    if (sys_mode == S_NORM) begin
      if (can_mode == 2'b11) want = M_LSTN;
      else if (can_mode != 2'b00) want = (!sup_ok && can_mode == 2'b01) ? M_OFFB : M_ACT;
    end else if (sys_mode == S_FNM) begin
      want = sup_ok ? M_ACT : M_LSTN;
    end
    if (want == M_ACT && mode != M_ACT && !txd) want = M_LSTN;

    if (kill)                nxt = M_OFF;
    else if (mode == M_OFF)  nxt = M_OFFL;
    else if (want != M_OFFB) nxt = want;
    else if (mode == M_OFFL) nxt = (bus_chg || wake_hit) ? M_OFFB : M_OFFL;
    else if (mode == M_OFFB) nxt = (silent && !bus_chg) ? M_OFFL : M_OFFB;
    else                     nxt = M_OFFB;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_OFF;
      bus_q <= 1'b0;
      run   <= '0;
      sil   <= '0;
    end else begin
      mode  <= nxt;
      bus_q <= bus_dom;
      if (bus_chg) run <= RW'(1);
      else if (run != RMAX_L) run <= run + 1'b1;
      if (bus_chg) sil <= '0;
      else if (!silent) sil <= sil + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= 2'd0;
      win      <= '0;
      wake_evt <= 1'b0;
    end else begin
      if (wake_hit) wake_evt <= 1'b1;
      else if (wake_clr) wake_evt <= 1'b0;

      if (!wk_on || wake_hit) begin
        stage <= 2'd0;
        win   <= '0;
      end else if (stage == 2'd0) begin
        win <= '0;
        if (dom_ok) stage <= 2'd1;
      end else if (win >= WIN_L) begin
        stage <= 2'd0;
        win   <= '0;
      end else begin
        win <= win + 1'b1;
        if (stage == 2'd1 && rec_ok) stage <= 2'd2;
      end
    end
  end

  assign tx_en     = (mode == M_ACT);
  assign bias_mid  = (mode == M_OFFB) || (mode == M_LSTN) || (mode == M_ACT);
  assign tx_rdy    = tx_en && sup_ok;
  assign rxd_low   = wake_evt;
  assign xcvr_mode = mode;

  wire unused_ok = (S_RST == S_STBY);
endmodule

// File: rtl/can_xcvr_ctrl_chk.sv
module can_xcvr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sys_mode,
  input logic [1:0] can_mode,
  input logic       wake_en,
  input logic       bat_uv,
  input logic       txd,
  input logic       wake_clr,
  input logic       wake_evt,
  input logic       tx_en,
  input logic [2:0] xcvr_mode
);
  AST_RESET_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode == 3'd1 && !bat_uv && xcvr_mode != 3'd0) |=> (xcvr_mode == 3'd1 || xcvr_mode == 3'd2)); // R1
  AST_TXD_BLOCKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_mode != 3'd4 && !txd) |=> (xcvr_mode != 3'd4)); // R2
  AST_MODE10_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_mode == 3'd4 && sys_mode == 3'd3 && can_mode == 2'b10 && !bat_uv) |=> (xcvr_mode == 3'd4)); // R4
  AST_WAKE_ONLY_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_evt) |-> ($past(wake_en) && ($past(xcvr_mode) == 3'd1 || $past(xcvr_mode) == 3'd2))); // R7
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bat_uv |=> (xcvr_mode == 3'd0 && !tx_en)); // R8
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !wake_clr) |=> wake_evt); // R11
endmodule

bind can_xcvr_ctrl can_xcvr_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .can_mode(can_mode),
  .wake_en(wake_en), .bat_uv(bat_uv), .txd(txd), .wake_clr(wake_clr),
  .wake_evt(wake_evt), .tx_en(tx_en), .xcvr_mode(xcvr_mode)
);

// File: tb/test_can_xcvr_ctrl.sv
module test_can_xcvr_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sys_mode = 3'd0;
  logic [1:0] can_mode = 2'b00;
  logic wake_en = 1'b0, sup_ok = 1'b1, bat_uv = 1'b0, txd = 1'b1;
  logic bus_dom = 1'b0, wake_clr = 1'b0;
  logic tx_en, bias_mid, tx_rdy, wake_evt, rxd_low;
  logic [2:0] xcvr_mode;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  can_xcvr_ctrl #(.DOM_MIN(4), .REC_MIN(4), .WAKE_TO(40), .SIL_TO(30)) i_can_xcvr_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .can_mode(can_mode),
    .wake_en(wake_en), .sup_ok(sup_ok), .bat_uv(bat_uv), .txd(txd),
    .bus_dom(bus_dom), .wake_clr(wake_clr), .tx_en(tx_en), .bias_mid(bias_mid),
    .tx_rdy(tx_rdy), .wake_evt(wake_evt), .rxd_low(rxd_low), .xcvr_mode(xcvr_mode)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus(input logic lvl, input int n);
    bus_dom = lvl;
    step(n);
  endtask

  task automatic t_reset;
    chk("R8 reset state", xcvr_mode, 0);
    chk("R12 reset tx_en", tx_en, 0);
    chk("R11 reset wake", wake_evt, 0);
    sys_mode = 3'd2;
    step(1);
    chk("R8 restart offline", xcvr_mode, 1);
    chk("R12 offline ground bias", bias_mid, 0);
  endtask

  task automatic t_modes;
    sys_mode = 3'd3; can_mode = 2'b01;
    step(1);
    chk("R1 mode 01 active", xcvr_mode, 4);
    chk("R12 active tx_en", tx_en, 1);
    chk("R12 active tx_rdy", tx_rdy, 1);
    can_mode = 2'b11; step(1);
    chk("R1 mode 11 listen", xcvr_mode, 3);
    chk("R12 listen bias", bias_mid, 1);
    chk("R12 listen tx off", tx_en, 0);
    can_mode = 2'b10; step(1);
    chk("R1 mode 10 active", xcvr_mode, 4);
    can_mode = 2'b00; step(1);
    chk("R1 mode 00 offline-bias", xcvr_mode, 2);
  endtask

  task automatic t_txd;
    txd = 1'b0; can_mode = 2'b01;
    step(3);
    chk("R2 txd low blocks active", xcvr_mode, 3);
    txd = 1'b1; step(1);
    chk("R2 active after txd high", xcvr_mode, 4);
    txd = 1'b0; step(3);
    chk("R2 txd low keeps active", xcvr_mode, 4);
    txd = 1'b1; step(1);
  endtask

  task automatic t_supply;
    sup_ok = 1'b0; step(1);
    chk("R3 mode 01 dip to offline-bias", xcvr_mode, 2);
    sup_ok = 1'b1; step(1);
    chk("R3 back to active", xcvr_mode, 4);
    can_mode = 2'b10; sup_ok = 1'b0; step(5);
    chk("R4 mode 10 holds active", xcvr_mode, 4);
    chk("R12 tx_rdy low on dip", tx_rdy, 0);
    sys_mode = 3'd1; step(2);
    chk("R4 reset leaves active", tx_en, 0);
    chk("R1 reset offline family", int'(xcvr_mode == 3'd1 || xcvr_mode == 3'd2), 1);
    sys_mode = 3'd4; step(1);
    chk("R5 forced normal low supply listen", xcvr_mode, 3);
    sup_ok = 1'b1; step(1);
    chk("R5 forced normal active", xcvr_mode, 4);
  endtask

  task automatic t_silence;
    sys_mode = 3'd2; step(1);
    bus(1'b1, 1); bus(1'b0, 2);
    chk("R6 activity gives offline-bias", xcvr_mode, 2);
    step(12);
    chk("R6 still offline-bias before timeout", xcvr_mode, 2);
    step(25);
    chk("R6 silence gives offline", xcvr_mode, 1);
    chk("R6 offline ground bias", bias_mid, 0);
    bus(1'b1, 2);
    chk("R6 bus edge gives offline-bias", xcvr_mode, 2);
    bus(1'b0, 60);
  endtask

  task automatic clear_wake;
    wake_clr = 1'b1; step(1); wake_clr = 1'b0; step(1);
  endtask

  task automatic t_wake;
    wake_en = 1'b0;
    bus(1'b1, 8); bus(1'b0, 8); bus(1'b1, 8); bus(1'b0, 3);
    chk("R7 no wake when disabled", wake_evt, 0);
    wake_en = 1'b1; step(60);
    bus(1'b1, 8); bus(1'b0, 8); bus(1'b1, 8); bus(1'b0, 3);
    chk("R7 wake detected", wake_evt, 1);
    chk("R7 rxd forced low", rxd_low, 1);
    step(20);
    chk("R11 wake stays set", wake_evt, 1);
    clear_wake;
    chk("R11 wake cleared", wake_evt, 0);
    chk("R11 rxd released", rxd_low, 0);
    step(60);
    bus(1'b1, 8); bus(1'b0, 2); bus(1'b1, 8); bus(1'b0, 60);
    chk("R10 short recessive not counted", wake_evt, 0);
    bus(1'b1, 8); bus(1'b0, 3); bus(1'b1, 1); bus(1'b0, 5); bus(1'b1, 8); bus(1'b0, 3);
    chk("R10 glitch tolerated", wake_evt, 1);
    clear_wake; step(60);
    bus(1'b1, 8); bus(1'b0, 50); bus(1'b1, 8); bus(1'b0, 60);
    chk("R9 timeout drops pattern", wake_evt, 0);
    bus(1'b1, 8); bus(1'b0, 50); bus(1'b1, 8); bus(1'b0, 8); bus(1'b1, 8); bus(1'b0, 3);
    chk("R9 new attempt after timeout", wake_evt, 1);
    clear_wake;
    wake_en = 1'b0;
  endtask

  task automatic t_off;
    sys_mode = 3'd3; can_mode = 2'b01; step(2);
    bat_uv = 1'b1; step(2);
    chk("R8 undervoltage off", xcvr_mode, 0);
    chk("R8 off tx disabled", tx_en, 0);
    chk("R8 off no bias", bias_mid, 0);
    bat_uv = 1'b0; sys_mode = 3'd2; step(1);
    chk("R8 restart offline after uv", xcvr_mode, 1);
    sys_mode = 3'd5; step(2);
    chk("R8 overtemperature off", xcvr_mode, 0);
    sys_mode = 3'd2; step(1);
    chk("R8 restart offline after overtemp", xcvr_mode, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_modes;
    t_txd;
    t_supply;
    t_silence;
    t_wake;
    t_off;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule